// File: doc/BRIEF.md
# Transmit ATM Cell Write FIFO

This block sits on the transmit side between an ATM layer device and the physical layer. The ATM layer writes 53-byte cells over a UTOPIA Level 2 style write bus: an active-low enable, a start-of-cell strobe, a data bus and an odd parity bit. The block checks each word and keeps only complete cells. A downstream cell processor pulls whole cells out, one word per read strobe. One clock drives both sides.

Configuration inputs pick the lane width (8 or 16 bits), the handshake style (whole-cell or per-octet space signalling), single-device or addressed multi-device operation, and an operating depth of 4, 8, 12 or 16 cells inside 16 cells of physical storage. Three single-cycle event outputs report parity errors, runt cells and cells dropped because the FIFO was full.

Top module: `utopia_tx_cell_fifo`

## Requirements
- R1: After reset, `rd_cell_avail`, `irq_parity`, `irq_runt` and `irq_overrun` are 0, and `tx_clav` is 1 in single-device mode.
- R2: With `cfg_wide`=0, a cell is 53 accepted beats. Each stored word is `{8'h00, tx_data[7:0]}`. A completed cell is read back word by word in write order.
- R3: With `cfg_wide`=1, a cell is 27 accepted beats of 16 bits. The last beat carries the pad byte, and all 16 bits of each word are stored and read back in order.
- R4: The operating depth is 4*(`cfg_depth`+1) cells. A start-of-cell beat accepted while that many cells are stored causes the whole cell to be dropped, and `irq_overrun` pulses for one cycle after that beat.
- R5: In cell-level mode (`cfg_octet_hs`=0), `tx_clav` is 1 exactly when stored cells plus the cell being written (0 or 1) is fewer than the operating depth.
- R6: In octet-level mode, `tx_clav` is 0 when the FIFO holds the operating depth. It is also 0 while the cell being written is the one that fills the FIFO and its next word index is at least the words per cell minus 4. Otherwise it is 1.
- R7: With `cfg_multi_phy`=1, a beat is accepted only when `tx_addr` equals `cfg_phy_addr`, and `tx_clav` is 0 whenever they differ.
- R8: A start-of-cell beat accepted while a cell is partly written discards the partial cell and pulses `irq_runt` in the next cycle. The new cell is then built from that beat onward.
- R9: Parity is odd over the active lanes (bits 7:0 when narrow, 15:0 when wide) plus `tx_prty`. Each accepted beat with even parity pulses `irq_parity` in the next cycle, and the cell is still stored.
- R10: `rd_cell_avail` is 1 while at least one complete cell is stored. `rd_en` pops one word and `rd_sop` marks the first word of a cell. Popping the last word frees the cell, and `rd_en` with no cell stored changes nothing.
- R11: An accepted beat without start-of-cell, arriving while no cell is being written, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multi_phy | input | 1 | 1: respond only to own address |
| cfg_octet_hs | input | 1 | 1: octet-level space signalling |
| cfg_wide | input | 1 | 1: 16-bit lanes, 0: 8-bit lanes |
| cfg_depth | input | 2 | Operating depth code, 4*(code+1) cells |
| cfg_phy_addr | input | 5 | Own device address |
| tx_addr | input | 5 | Address from the ATM layer |
| tx_enb_n | input | 1 | Active-low write enable |
| tx_soc | input | 1 | Start-of-cell on this beat |
| tx_data | input | 16 | Write data |
| tx_prty | input | 1 | Odd parity over active lanes |
| tx_clav | output | 1 | Space available indication |
| rd_en | input | 1 | Downstream pops one word |
| rd_data | output | 16 | Word at the read point |
| rd_sop | output | 1 | Read word is first of its cell |
| rd_cell_avail | output | 1 | At least one whole cell stored |
| irq_parity | output | 1 | Parity error event |
| irq_runt | output | 1 | Runt cell event |
| irq_overrun | output | 1 | Cell dropped on full FIFO |

## Verification
The assertions assume that lane width and operating depth stay fixed while any cell is stored or partly written. A shrinking depth or a width change mid-cell would break the word-count and room invariants. The stimulus changes width and depth only when the FIFO is empty and the write side is idle. It changes the handshake style and the address mode freely, because they affect only the space indication and beat acceptance. Random stimulus mixes runts, stray beats, off-address cells and parity faults inside those limits.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

   // Number of bus words forming one cell for the chosen lane width.
   function automatic int unsigned cell_words(input logic wide, input int unsigned cell_bytes);
      return wide ? (cell_bytes + 1) / 2 : cell_bytes;
   endfunction

   // Operating depth in cells for a two-bit depth code.
   function automatic int unsigned depth_from_code(input logic [1:0] code, input int unsigned max_cells);
      return (int'(code) + 1) * (max_cells / 4);
   endfunction

endpackage

// File: rtl/tcf_wr_ctrl.sv
module tcf_wr_ctrl #(
   parameter int DATA_W       = 16,
   parameter int CNT_W        = 5,
   parameter int OFF_W        = 6,
   parameter bit CHECK_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              soc,
   input  logic [DATA_W-1:0] data,
   input  logic              prty,
   input  logic              wide,
   input  logic [CNT_W-1:0]  depth_cells,
   input  logic [CNT_W-1:0]  count,
   input  logic [OFF_W-1:0]  wpc,
   output logic              mem_we,
   output logic [OFF_W-1:0]  mem_off,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              commit,
   output logic              in_cell,
   output logic [OFF_W-1:0]  wr_off,
   output logic              runt_p,
   output logic              ovf_p,
   output logic              par_p
);

   logic dropping;
   logic last_w;
   logic room;

   always_comb begin
      mem_wdata = wide ? data : {{(DATA_W-8){1'b0}}, data[7:0]};
      last_w    = (wr_off == wpc - OFF_W'(1));
      room      = (count < depth_cells);
      mem_we    = 1'b0;
      mem_off   = wr_off;
      commit    = 1'b0;
      if (acc && soc) begin
         if (room) begin
            mem_we  = 1'b1;
            mem_off = '0;
         end
      end else if (acc && in_cell) begin
         mem_we = 1'b1;
         commit = last_w;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cell  <= 1'b0;
         dropping <= 1'b0;
         wr_off   <= '0;
         runt_p   <= 1'b0;
         ovf_p    <= 1'b0;
      end else begin
         runt_p <= acc && soc && (in_cell || dropping);
         ovf_p  <= acc && soc && !room;
         if (acc) begin
            if (soc) begin
               wr_off   <= OFF_W'(1);
               in_cell  <= room;
               dropping <= !room;
            end else if (in_cell || dropping) begin
               if (last_w) begin
                  wr_off   <= '0;
                  in_cell  <= 1'b0;
                  dropping <= 1'b0;
               end else begin
                  wr_off <= wr_off + OFF_W'(1);
               end
            end
         end
      end
   end

   generate
      if (CHECK_PARITY) begin : g_par
         logic par_q;
         always_ff @(posedge clk) begin
            if (!rst_n) par_q <= 1'b0;
            else        par_q <= acc && !(^{mem_wdata, prty});
         end
         assign par_p = par_q;
      end else begin : g_nopar
         assign par_p = 1'b0;
      end
   endgenerate

   // R2/R3: the word index inside an open cell stays within the cell
   assert_off_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cell || dropping) |-> (wr_off < wpc && wr_off != '0));

   // R4: a cell is only committed when the FIFO has room for it
   assert_commit_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (count < depth_cells));

   // R8: a runt event always follows an accepted start-of-cell beat
   assert_runt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      runt_p |-> $past(acc && soc));

endmodule

// File: rtl/tcf_store.sv
module tcf_store #(
   parameter int DATA_W    = 16,
   parameter int MAX_CELLS = 16,
   parameter int WMAX      = 53,
   parameter int CNT_W     = 5,
   parameter int OFF_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [OFF_W-1:0]  woff,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic              rd_en,
   input  logic [OFF_W-1:0]  wpc,
   output logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sop,
   output logic              avail
);

   localparam int SLOT_W = $clog2(MAX_CELLS);
   localparam int DEPTH  = MAX_CELLS * WMAX;
   localparam int IDX_W  = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [SLOT_W-1:0] tail, head;
   logic [OFF_W-1:0]  rd_off;
   logic [IDX_W-1:0]  widx, ridx;
   logic              pop, pop_last;

   always_comb begin
      widx     = IDX_W'(tail) * IDX_W'(WMAX) + IDX_W'(woff);
      ridx     = IDX_W'(head) * IDX_W'(WMAX) + IDX_W'(rd_off);
      avail    = (count != '0);
      pop      = rd_en && avail;
      pop_last = pop && (rd_off == wpc - OFF_W'(1));
      rd_data  = mem[ridx];
      rd_sop   = (rd_off == '0);
   end

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail   <= '0;
         head   <= '0;
         rd_off <= '0;
         count  <= '0;
      end else begin
         if (commit)
            tail <= (tail == SLOT_W'(MAX_CELLS-1)) ? '0 : tail + SLOT_W'(1);
         if (pop) begin
            if (pop_last) begin
               rd_off <= '0;
               head   <= (head == SLOT_W'(MAX_CELLS-1)) ? '0 : head + SLOT_W'(1);
            end else begin
               rd_off <= rd_off + OFF_W'(1);
            end
         end
         count <= count + CNT_W'(commit) - CNT_W'(pop_last);
      end
   end

   // R4: physical storage is never exceeded
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(MAX_CELLS));

   // R10: a read strobe on an empty FIFO leaves the cell count alone
   assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !avail) |=> (count == $past(count) + CNT_W'($past(commit))));

endmodule

// File: rtl/tcf_clav.sv
module tcf_clav #(
   parameter int CNT_W      = 5,
   parameter int OFF_W      = 6,
   parameter int OCT_MARGIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             octet,
   input  logic             sel,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] depth_cells,
   input  logic             in_cell,
   input  logic [OFF_W-1:0] wr_off,
   input  logic [OFF_W-1:0] wpc,
   output logic             clav
);

   logic base_cell, base_oct, near_end;

   always_comb begin
      base_cell = (count + CNT_W'(in_cell)) < depth_cells;
      near_end  = in_cell && (count + CNT_W'(1) == depth_cells) &&
                  (wr_off >= wpc - OFF_W'(OCT_MARGIN));
      base_oct  = (count < depth_cells) && !near_end;
      clav      = sel && (octet ? base_oct : base_cell);
   end

   // R5/R6: space is never offered once the operating depth is reached
   assert_clav_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clav |-> (count < depth_cells));

endmodule

// File: rtl/utopia_tx_cell_fifo.sv
module utopia_tx_cell_fifo #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 5,
   parameter int CELL_BYTES   = 53,
   parameter int MAX_CELLS    = 16,
   parameter int OCT_MARGIN   = 4,
   parameter bit CHECK_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_multi_phy,
   input  logic              cfg_octet_hs,
   input  logic              cfg_wide,
   input  logic [1:0]        cfg_depth,
   input  logic [ADDR_W-1:0] cfg_phy_addr,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_enb_n,
   input  logic              tx_soc,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_prty,
   output logic              tx_clav,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sop,
   output logic              rd_cell_avail,
   output logic              irq_parity,
   output logic              irq_runt,
   output logic              irq_overrun
);
   import tcf_pkg::*;

   localparam int WMAX   = CELL_BYTES;
   localparam int WWIDE  = (CELL_BYTES + 1) / 2;
   localparam int CNT_W  = $clog2(MAX_CELLS + 1);
   localparam int OFF_W  = $clog2(WMAX + 1);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("DATA_W must be 16");
      end
      if (MAX_CELLS < 4 || (MAX_CELLS % 4) != 0) begin : g_bad_cells
         $error("MAX_CELLS must be a multiple of 4");
      end
      if (OCT_MARGIN < 1 || OCT_MARGIN >= WWIDE) begin : g_bad_margin
         $error("OCT_MARGIN out of range");
      end
   endgenerate

   logic              sel, acc;
   logic [CNT_W-1:0]  depth_cells, count;
   logic [OFF_W-1:0]  wpc, mem_off, wr_off;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_we, commit, in_cell;

   always_comb begin
      sel         = !cfg_multi_phy || (tx_addr == cfg_phy_addr);
      acc         = !tx_enb_n && sel;
      depth_cells = CNT_W'(depth_from_code(cfg_depth, MAX_CELLS));
      wpc         = OFF_W'(cell_words(cfg_wide, CELL_BYTES));
   end

   tcf_wr_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .CHECK_PARITY(CHECK_PARITY)) u_wr (
      .clk(clk), .rst_n(rst_n), .acc(acc), .soc(tx_soc), .data(tx_data), .prty(tx_prty),
      .wide(cfg_wide), .depth_cells(depth_cells), .count(count), .wpc(wpc),
      .mem_we(mem_we), .mem_off(mem_off), .mem_wdata(mem_wdata), .commit(commit),
      .in_cell(in_cell), .wr_off(wr_off), .runt_p(irq_runt), .ovf_p(irq_overrun),
      .par_p(irq_parity));

   tcf_store #(.DATA_W(DATA_W), .MAX_CELLS(MAX_CELLS), .WMAX(WMAX), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .woff(mem_off), .wdata(mem_wdata),
      .commit(commit), .rd_en(rd_en), .wpc(wpc), .count(count), .rd_data(rd_data),
      .rd_sop(rd_sop), .avail(rd_cell_avail));

   tcf_clav #(.CNT_W(CNT_W), .OFF_W(OFF_W), .OCT_MARGIN(OCT_MARGIN)) u_clav (
      .clk(clk), .rst_n(rst_n), .octet(cfg_octet_hs), .sel(sel), .count(count),
      .depth_cells(depth_cells), .in_cell(in_cell), .wr_off(wr_off), .wpc(wpc),
      .clav(tx_clav));

   // R7: an unaddressed device never offers space
   assert_clav_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clav |-> (!cfg_multi_phy || tx_addr == cfg_phy_addr));

   // R10: a stored cell is announced only after a complete write
   assert_avail_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_cell_avail) |-> $past(commit));

endmodule

// File: tb/utopia_tx_cell_fifo_bench.sv
`timescale 1ns/1ps
module utopia_tx_cell_fifo_bench;

   localparam logic [4:0] PHY = 5'd9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_multi_phy = 1'b0, cfg_octet_hs = 1'b0, cfg_wide = 1'b1;
   logic [1:0]  cfg_depth = 2'd0;
   logic [4:0]  cfg_phy_addr = PHY;
   logic [4:0]  tx_addr = PHY;
   logic        tx_enb_n = 1'b1, tx_soc = 1'b0, tx_prty = 1'b0, rd_en = 1'b0;
   logic [15:0] tx_data = '0;
   logic        tx_clav, rd_sop, rd_cell_avail, irq_parity, irq_runt, irq_overrun;
   logic [15:0] rd_data;

   always #2 clk = ~clk;

   utopia_tx_cell_fifo u_utopia_tx_cell_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_multi_phy(cfg_multi_phy), .cfg_octet_hs(cfg_octet_hs),
      .cfg_wide(cfg_wide), .cfg_depth(cfg_depth), .cfg_phy_addr(cfg_phy_addr),
      .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
      .tx_prty(tx_prty), .tx_clav(tx_clav), .rd_en(rd_en), .rd_data(rd_data),
      .rd_sop(rd_sop), .rd_cell_avail(rd_cell_avail), .irq_parity(irq_parity),
      .irq_runt(irq_runt), .irq_overrun(irq_overrun));

   int nchk = 0, nfail = 0;
   bit done = 0;
   int m_cells = 0, m_off = 0;
   bit m_in = 0, m_drop = 0;
   logic [15:0] cur[$];
   logic [15:0] expq[$];

   function automatic int depth_of();  return (int'(cfg_depth) + 1) * 4; endfunction
   function automatic int wpc_of();    return cfg_wide ? 27 : 53;        endfunction

   function automatic bit exp_clav(input logic [4:0] a);
      if (cfg_multi_phy && a != PHY) return 1'b0;
      if (cfg_octet_hs)
         return (m_cells < depth_of()) &&
                !(m_in && m_cells + 1 == depth_of() && m_off >= wpc_of() - 4);
      return (m_cells + int'(m_in)) < depth_of();
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic beat(input logic [15:0] d, input bit soc, input bit bad, input logic [4:0] a);
      logic [15:0] sw;
      bit acc, e_par, e_runt, e_ovf, ec;
      string ctag;
      sw = cfg_wide ? d : {8'h00, d[7:0]};
      tx_data = d; tx_soc = soc; tx_addr = a; tx_enb_n = 1'b0;
      tx_prty = (~^sw) ^ bad;
      acc    = !cfg_multi_phy || a == PHY;
      e_par  = acc && bad;
      e_runt = acc && soc && (m_in || m_drop);
      e_ovf  = acc && soc && (m_cells >= depth_of());
      if (acc) begin
         if (soc) begin
            cur.delete();
            m_off = 1;
            if (e_ovf) begin m_drop = 1; m_in = 0; end
            else begin m_in = 1; m_drop = 0; cur.push_back(sw); end
         end else if (m_in) begin
            cur.push_back(sw);
            if (m_off == wpc_of() - 1) begin
               foreach (cur[i]) expq.push_back(cur[i]);
               cur.delete(); m_cells++; m_in = 0; m_off = 0;
            end else m_off++;
         end else if (m_drop) begin
            if (m_off == wpc_of() - 1) begin m_drop = 0; m_off = 0; end
            else m_off++;
         end
      end
      @(posedge clk); #1;
      check(irq_parity == e_par,  "R9", irq_parity, e_par);
      check(irq_runt == e_runt,   "R8", irq_runt, e_runt);
      check(irq_overrun == e_ovf, "R4", irq_overrun, e_ovf);
      ec = exp_clav(a);
      ctag = (cfg_multi_phy && a != PHY) ? "R7" : (cfg_octet_hs ? "R6" : "R5");
      check(tx_clav == ec, ctag, tx_clav, ec);
   endtask

   task automatic idle(input int n);
      tx_enb_n = 1'b1; tx_soc = 1'b0;
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_cell(input int nw, input logic [4:0] a, input int bad_at);
      for (int i = 0; i < nw; i++) beat(16'($urandom), i == 0, i == bad_at, a);
      idle(1);
   endtask

   task automatic read_cell();
      check(rd_cell_avail == (m_cells > 0), "R10", rd_cell_avail, m_cells > 0);
      if (m_cells == 0) return;
      for (int i = 0; i < wpc_of(); i++) begin
         rd_en = 1'b1;
         check(rd_data == expq[0], cfg_wide ? "R3" : "R2", rd_data, expq[0]);
         check(rd_sop == (i == 0), "R10", rd_sop, i == 0);
         void'(expq.pop_front());
         @(posedge clk); #1;
      end
      rd_en = 1'b0;
      m_cells--;
   endtask

   task automatic drain();
      while (m_cells > 0) read_cell();
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset state
      check(rd_cell_avail == 0, "R1", rd_cell_avail, 0);
      check(tx_clav == 1, "R1", tx_clav, 1);
      check({irq_parity, irq_runt, irq_overrun} == 3'b000, "R1", {irq_parity, irq_runt, irq_overrun}, 0);

      // R3/R4/R5: wide lanes, depth 4, fill then overflow
      for (int c = 0; c < 5; c++) send_cell(27, PHY, -1);
      drain();
      // R10: read strobe while empty
      rd_en = 1'b1; @(posedge clk); #1; rd_en = 1'b0;
      check(rd_cell_avail == 0, "R10", rd_cell_avail, 0);

      // R11: stray beats outside a cell
      for (int i = 0; i < 3; i++) beat(16'($urandom), 1'b0, 1'b0, PHY);
      idle(1);
      check(rd_cell_avail == 0, "R11", rd_cell_avail, 0);
      send_cell(27, PHY, -1);
      read_cell();

      // R8: runt followed by a full cell
      for (int i = 0; i < 10; i++) beat(16'($urandom), i == 0, 1'b0, PHY);
      send_cell(27, PHY, -1);
      check(m_cells == 1, "R8", m_cells, 1);
      read_cell();

      // R9: parity faults still store the cell
      send_cell(27, PHY, 5);
      send_cell(27, PHY, 0);
      drain();

      // R2/R6: narrow lanes, octet handshake, depth 8
      cfg_wide = 1'b0; cfg_octet_hs = 1'b1; cfg_depth = 2'd1;
      idle(1);
      for (int c = 0; c < 9; c++) send_cell(53, PHY, (c == 3) ? 17 : -1);
      drain();

      // R7: addressed mode
      cfg_wide = 1'b1; cfg_octet_hs = 1'b0; cfg_depth = 2'd3; cfg_multi_phy = 1'b1;
      idle(1);
      send_cell(27, 5'd3, -1);
      check(rd_cell_avail == 0, "R7", rd_cell_avail, 0);
      send_cell(27, PHY, -1);
      drain();

      // random mix
      for (int it = 0; it < 80; it++) begin
         int act;
         logic [4:0] a;
         act = int'($urandom % 8);
         a = ($urandom % 4 == 0) ? 5'($urandom) : PHY;
         cfg_octet_hs = 1'($urandom);
         if (act < 4) send_cell(27, a, ($urandom % 8 == 0) ? int'($urandom % 27) : -1);
         else if (act == 4) begin
            for (int i = 0; i < 1 + int'($urandom % 20); i++) beat(16'($urandom), i == 0, 1'b0, a);
            idle(1);
         end else if (act < 7) read_cell();
         else begin beat(16'($urandom), 1'b0, 1'b0, a); idle(1); end
      end
      send_cell(27, PHY, -1);
      drain();
      idle(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule